// File: doc/BRIEF.md
# Byte/Word ALU With Status Flags

A purely combinational arithmetic and logic unit for a 16-bit microcontroller datapath. Each evaluation takes a source operand, a destination operand, a 4-bit operation code, a size select (byte or word) and the four incoming status flags. It returns the result, a write strobe telling the register file whether the result is to be stored, the updated status flags and a mask of the flags that the operation is allowed to change.

Arithmetic covers binary add and subtract, each with and without the incoming carry, compare, and packed-BCD decimal add. Logic covers AND, bit-test, bit-clear, bit-set and XOR. The single-operand group covers rotate right through carry, arithmetic shift right, byte swap and sign extension; these take their operand from the destination input. Subtraction is formed as destination plus inverted source plus one (or plus the incoming carry), so C set after a subtract means that no borrow occurred. Operand fetch, decode and the register file lie outside the block.

Top module: `bw_alu`

## Requirements
- R1: The operation code op_i selects: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 decimal add, 6 AND, 7 bit-test, 8 bit-clear, 9 bit-set, 10 XOR, 11 rotate right through carry, 12 arithmetic shift right, 13 swap bytes, 14 sign-extend, 15 unassigned. wr_o is 0 for compare, bit-test and code 15 and 1 for all others; code 15 gives result 0 and changes no flag.
- R2: Add computes dst + src, add with carry computes dst + src + C; C is set when the unsigned sum does not fit the selected width and V is set when the signed sum does not fit.
- R3: Where N and Z may change, N equals the sign bit of the result (bit 7 in byte mode, bit 15 in word mode) and Z is set exactly when all bits of the selected width are zero.
- R4: Subtract computes dst + ~src + 1, subtract with carry computes dst + ~src + C, and compare computes the subtract value without writing it; C is the carry out of that sum and V is set when the signed difference does not fit.
- R5: Decimal add sums dst, src and C as packed BCD digits; C is set when the decimal sum exceeds 99 (byte) or 9999 (word), and V is not changed (mask 0111).
- R6: Bit-clear gives dst AND NOT src and bit-set gives dst OR src, with a zero flag mask so all flags keep their incoming values.
- R7: AND and bit-test give dst AND src, set C when the result is nonzero and clear V; bit-test does not write.
- R8: XOR gives dst XOR src, sets C when the result is nonzero and sets V only when both operands have their sign bit set.
- R9: Rotate right through carry puts the incoming C into the sign bit and the operand LSB into C; arithmetic shift right keeps the sign bit and moves the LSB into C; both clear V.
- R10: In byte mode every operation except swap and sign-extend yields zeros in result bits 15:8 and derives all flags from bits 7:0 only.
- R11: flags_i, flags_o and fmask_o use bit 3 = V, bit 2 = N, bit 1 = Z, bit 0 = C; every flag whose fmask_o bit is 0 leaves equal to its flags_i value.
- R12: Swap bytes and sign-extend ignore the size select and work on the full word; swap exchanges bits 15:8 with 7:0 and changes no flag; sign-extend copies bit 7 into bits 15:8, sets N and Z from the word, sets C when the result is nonzero and clears V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand; the operand of single-operand operations |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte size, 0 word size |
| flags_i | input | 4 | Incoming flags {V,N,Z,C} |
| res_o | output | 16 | Result |
| wr_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | Updated flags {V,N,Z,C} |
| fmask_o | output | 4 | Flags this operation may change {V,N,Z,C} |

## Verification
Every output is due in the same cycle as its stimulus, with no register between the inputs and the result, flags, mask or write strobe. The driver applies each operand set on a falling clock edge and queues the expected values; the monitor pops and compares on the following rising edge, half a period later, once the combinational paths have settled and before the next stimulus is applied. Expected values come from an integer model of the requirements plus a set of hand-worked cases at the carry, overflow, decimal and byte-size boundaries.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_DADD = 4'd5,
    OP_AND  = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_RRC  = 4'd11,
    OP_RRA  = 4'd12,
    OP_SWPB = 4'd13,
    OP_SXT  = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/bw_alu_arith.sv
module bw_alu_arith #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              sub_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);

  logic [DATA_W-1:0] opb;
  logic [DATA_W:0]   sum_w;
  logic [BYTE_W:0]   sum_b;
  logic              da, db, dr;

  assign opb   = sub_i ? ~src_i : src_i;
  assign sum_w = {1'b0, dst_i} + {1'b0, opb} + {{DATA_W{1'b0}}, cin_i};
  assign sum_b = {1'b0, dst_i[BYTE_W-1:0]} + {1'b0, opb[BYTE_W-1:0]}
               + {{BYTE_W{1'b0}}, cin_i};

  always_comb begin
    if (byte_i) begin
      res_o = {{(DATA_W-BYTE_W){1'b0}}, sum_b[BYTE_W-1:0]};
      c_o   = sum_b[BYTE_W];
      da    = dst_i[BYTE_W-1];
      db    = opb[BYTE_W-1];
      dr    = sum_b[BYTE_W-1];
    end else begin
      res_o = sum_w[DATA_W-1:0];
      c_o   = sum_w[DATA_W];
      da    = dst_i[DATA_W-1];
      db    = opb[DATA_W-1];
      dr    = sum_w[DATA_W-1];
    end
  end

  // signed overflow: like-signed addends, result sign differs
  assign v_o = (da == db) && (dr != da);

endmodule

// File: rtl/bw_alu_bcd.sv
module bw_alu_bcd #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);

  localparam int NDIG   = DATA_W / 4;
  localparam int NDIG_B = BYTE_W / 4;

  logic [NDIG:0]     dc;
  logic [DATA_W-1:0] raw;

  assign dc[0] = cin_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [4:0] s5;
    logic [4:0] adj;
    assign s5  = {1'b0, dst_i[4*g+:4]} + {1'b0, src_i[4*g+:4]} + {4'd0, dc[g]};
    assign adj = s5 + 5'd6;
    assign dc[g+1]     = (s5 > 5'd9);
    assign raw[4*g+:4] = dc[g+1] ? adj[3:0] : s5[3:0];
  end

  assign res_o = byte_i ? {{(DATA_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]} : raw;
  assign c_o   = byte_i ? dc[NDIG_B] : dc[NDIG];

endmodule

// File: rtl/bw_alu_logic.sv
module bw_alu_logic
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    unique case (op_i)
      OP_BIC:  res_o = dst_i & ~src_i;
      OP_BIS:  res_o = dst_i | src_i;
      OP_XOR:  res_o = dst_i ^ src_i;
      default: res_o = dst_i & src_i;
    endcase
  end

endmodule

// File: rtl/bw_alu_shift.sv
module bw_alu_shift
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);

  localparam int HALF = DATA_W / 2;

  logic [BYTE_W-1:0] lo;
  logic              top_in;
  logic [DATA_W-1:0] rot;

  assign lo = dst_i[BYTE_W-1:0];

  always_comb begin
    if (op_i == OP_RRC) top_in = cin_i;
    else                top_in = byte_i ? dst_i[BYTE_W-1] : dst_i[DATA_W-1];
    if (byte_i) rot = {{(DATA_W-BYTE_W){1'b0}}, top_in, lo[BYTE_W-1:1]};
    else        rot = {top_in, dst_i[DATA_W-1:1]};
  end

  always_comb begin
    unique case (op_i)
      OP_SWPB: res_o = {dst_i[HALF-1:0], dst_i[DATA_W-1:HALF]};
      OP_SXT:  res_o = {{(DATA_W-BYTE_W){lo[BYTE_W-1]}}, lo};
      default: res_o = rot;
    endcase
  end

  assign c_o = dst_i[0];

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [3:0]        op_i,
  input  logic              byte_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o,
  output logic [3:0]        flags_o,
  output logic [3:0]        fmask_o
);

  alu_op_e    op;
  alu_flags_t fin, fnew, fmask;
  logic       is_sub, arith_cin, word_only, eff_byte;

  logic [DATA_W-1:0] ar_res, bcd_res, lg_res, sh_res, res_sel, res_m;
  logic              ar_c, ar_v, bcd_c, sh_c;
  logic              s_msb, d_msb, r_msb, r_zero;

  assign op  = alu_op_e'(op_i);
  assign fin = alu_flags_t'(flags_i);

  assign is_sub    = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign word_only = (op == OP_SWPB) || (op == OP_SXT);
  assign eff_byte  = byte_i && !word_only;

  always_comb begin
    unique case (op)
      OP_ADD:                 arith_cin = 1'b0;
      OP_SUB, OP_CMP:         arith_cin = 1'b1;
      default:                arith_cin = fin.c;
    endcase
  end

  bw_alu_arith #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_arith (
    .dst_i  (dst_i),
    .src_i  (src_i),
    .sub_i  (is_sub),
    .cin_i  (arith_cin),
    .byte_i (byte_i),
    .res_o  (ar_res),
    .c_o    (ar_c),
    .v_o    (ar_v)
  );

  bw_alu_bcd #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bcd (
    .dst_i  (dst_i),
    .src_i  (src_i),
    .cin_i  (fin.c),
    .byte_i (byte_i),
    .res_o  (bcd_res),
    .c_o    (bcd_c)
  );

  bw_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i  (op),
    .dst_i (dst_i),
    .src_i (src_i),
    .res_o (lg_res)
  );

  bw_alu_shift #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shift (
    .op_i   (op),
    .dst_i  (dst_i),
    .cin_i  (fin.c),
    .byte_i (byte_i),
    .res_o  (sh_res),
    .c_o    (sh_c)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: res_sel = ar_res;
      OP_DADD:                                  res_sel = bcd_res;
      OP_AND, OP_BIT, OP_BIC, OP_BIS, OP_XOR:   res_sel = lg_res;
      OP_RRC, OP_RRA, OP_SWPB, OP_SXT:          res_sel = sh_res;
      default:                                  res_sel = '0;
    endcase
  end

  assign res_m = eff_byte ? {{(DATA_W-BYTE_W){1'b0}}, res_sel[BYTE_W-1:0]} : res_sel;

  assign s_msb  = eff_byte ? src_i[BYTE_W-1] : src_i[DATA_W-1];
  assign d_msb  = eff_byte ? dst_i[BYTE_W-1] : dst_i[DATA_W-1];
  assign r_msb  = eff_byte ? res_m[BYTE_W-1] : res_m[DATA_W-1];
  assign r_zero = (res_m == '0);

  always_comb begin
    fnew   = '0;
    fnew.n = r_msb;
    fnew.z = r_zero;
    fmask  = '0;
    wr_o   = 1'b1;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        fnew.c = ar_c;
        fnew.v = ar_v;
        fmask  = 4'b1111;
        wr_o   = (op != OP_CMP);
      end
      OP_DADD: begin
        fnew.c = bcd_c;
        fmask  = 4'b0111;
      end
      OP_AND, OP_BIT, OP_SXT: begin
        fnew.c = !r_zero;
        fmask  = 4'b1111;
        wr_o   = (op != OP_BIT);
      end
      OP_XOR: begin
        fnew.c = !r_zero;
        fnew.v = s_msb && d_msb;
        fmask  = 4'b1111;
      end
      OP_RRC, OP_RRA: begin
        fnew.c = sh_c;
        fmask  = 4'b1111;
      end
      OP_NONE: wr_o = 1'b0;
      default: ;
    endcase
  end

  assign res_o   = res_m;
  assign fmask_o = fmask;
  assign flags_o = (fnew & fmask) | (fin & ~fmask);

endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [3:0]        op_i,
  input logic              byte_i,
  input logic [3:0]        flags_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_o,
  input logic [3:0]        flags_o,
  input logic [3:0]        fmask_o
);

  logic narrow;
  logic msb;
  logic zero;

  always_comb begin
    narrow = byte_i && (op_i != 4'd13) && (op_i != 4'd14);
    msb    = narrow ? res_o[BYTE_W-1] : res_o[DATA_W-1];
    zero   = narrow ? (res_o[BYTE_W-1:0] == '0) : (res_o == '0);

    a_r10_byte_upper_zero: assert (!narrow || res_o[DATA_W-1:BYTE_W] == '0)
      else $error("byte result has upper bits set");
    a_r11_unmasked_kept: assert (((flags_o ^ flags_i) & ~fmask_o) == 4'b0000)
      else $error("flag outside mask changed");
    a_r6_setclr_no_flags: assert (!(op_i == 4'd8 || op_i == 4'd9) || flags_o == flags_i)
      else $error("bit set/clear changed flags");
    a_r1_no_write: assert (!(op_i == 4'd4 || op_i == 4'd7 || op_i == 4'd15) || !wr_o)
      else $error("non-writing op asserted write");
    a_r3_n_sign: assert (!fmask_o[2] || flags_o[2] == msb)
      else $error("N not equal to result sign");
    a_r3_z_zero: assert (!fmask_o[1] || flags_o[1] == zero)
      else $error("Z not equal to result zero");
    a_r5_dadd_v_kept: assert (op_i != 4'd5 || flags_o[3] == flags_i[3])
      else $error("decimal add changed V");
  end

endmodule

bind bw_alu bw_alu_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .src_i   (src_i),
  .dst_i   (dst_i),
  .op_i    (op_i),
  .byte_i  (byte_i),
  .flags_i (flags_i),
  .res_o   (res_o),
  .wr_o    (wr_o),
  .flags_o (flags_o),
  .fmask_o (fmask_o)
);

// File: tb/bw_alu_tb.sv
`timescale 1ns/1ps
module bw_alu_tb;

  typedef struct {
    logic [15:0] res;
    logic        wr;
    logic [3:0]  flg;
    logic [3:0]  msk;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src = '0, dst = '0;
  logic [3:0]  op = '0, fl = '0;
  logic        byt = 1'b0;
  logic [15:0] res;
  logic        wr;
  logic [3:0]  flo, fmk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  bw_alu u_dut (
    .src_i(src), .dst_i(dst), .op_i(op), .byte_i(byt), .flags_i(fl),
    .res_o(res), .wr_o(wr), .flags_o(flo), .fmask_o(fmk)
  );

  function automatic int sx(int v, int w);
    return (v & (1 << (w-1))) ? v - (1 << w) : v;
  endfunction

  function automatic int bcd2bin(int v);
    return (v & 15) + ((v >> 4) & 15) * 10 + ((v >> 8) & 15) * 100 + ((v >> 12) & 15) * 1000;
  endfunction

  function automatic int bin2bcd(int v);
    return (v % 10) | (((v / 10) % 10) << 4) | (((v / 100) % 10) << 8) | (((v / 1000) % 10) << 12);
  endfunction

  function automatic exp_t model(int o, int s, int d, bit bsel, logic [3:0] f, string tag);
    exp_t e;
    int w, m, sb, a, b, c, r, sv, lim;
    bit nv, nc;
    logic [3:0] mk, nf;
    w  = (bsel && o != 13 && o != 14) ? 8 : 16;
    m  = (1 << w) - 1;
    sb = 1 << (w - 1);
    a  = d & m;
    b  = s & m;
    c  = f[0];
    nv = 0; nc = 0; mk = 4'b1111; e.wr = 1; r = 0;
    case (o)
      0, 1: begin
        r  = a + b + (o == 1 ? c : 0);
        nc = r > m;
        sv = sx(a, w) + sx(b, w) + (o == 1 ? c : 0);
        nv = (sv > sb - 1) || (sv < -sb);
      end
      2, 3, 4: begin
        r  = a + ((~b) & m) + (o == 3 ? c : 1);
        nc = r > m;
        sv = sx(a, w) - sx(b, w) - (o == 3 ? 1 - c : 0);
        nv = (sv > sb - 1) || (sv < -sb);
        e.wr = (o != 4);
      end
      5: begin
        lim = bsel ? 100 : 10000;
        sv  = bcd2bin(a) + bcd2bin(b) + c;
        nc  = sv >= lim;
        r   = bin2bcd(sv % lim);
        mk  = 4'b0111;
      end
      6, 7: begin r = a & b; nc = r != 0; e.wr = (o != 7); end
      8: begin r = a & ~b; mk = 0; end
      9: begin r = a | b; mk = 0; end
      10: begin r = a ^ b; nc = r != 0; nv = ((a & sb) != 0) && ((b & sb) != 0); end
      11: begin r = (a >> 1) | (c ? sb : 0); nc = a & 1; end
      12: begin r = (a >> 1) | (a & sb); nc = a & 1; end
      13: begin r = ((d >> 8) & 255) | ((d & 255) << 8); mk = 0; end
      14: begin r = (d & 128) ? ((d & 255) | 16'hFF00) : (d & 255); nc = (r & m) != 0; end
      default: begin r = 0; mk = 0; e.wr = 0; end
    endcase
    r = r & m;
    nf = {nv, (r & sb) != 0, r == 0, nc};
    e.res = r[15:0];
    e.msk = mk;
    e.flg = (nf & mk) | (f & ~mk);
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(int o, int s, int d, bit bsel, logic [3:0] f, exp_t e);
    @(negedge clk);
    op = o[3:0]; src = s[15:0]; dst = d[15:0]; byt = bsel; fl = f;
    q.push_back(e);
  endtask

  function automatic exp_t hand(int r, bit w, logic [3:0] f, logic [3:0] mk, string tag);
    exp_t e;
    e.res = r[15:0]; e.wr = w; e.flg = f; e.msk = mk; e.tag = tag;
    return e;
  endfunction

  // monitor: results are combinational, compared half a period after drive
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (res !== e.res || wr !== e.wr || flo !== e.flg || fmk !== e.msk) begin
        fails++;
        $display("FAIL %s: res=%h wr=%b flags=%b mask=%b expected res=%h wr=%b flags=%b mask=%b",
                 e.tag, res, wr, flo, fmk, e.res, e.wr, e.flg, e.msk);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state: zero inputs give add of zeros
    drive(0, 0, 0, 0, 4'b0000, hand(16'h0000, 1, 4'b0010, 4'b1111, "R3 reset-state add"));
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    drive(0, 16'h0001, 16'h7FFF, 0, 4'b0000, hand(16'h8000, 1, 4'b1100, 4'b1111, "R2 word add overflow"));
    drive(0, 16'h12FF, 16'hAB01, 1, 4'b0000, hand(16'h0000, 1, 4'b0011, 4'b1111, "R10 byte add carry"));
    drive(2, 16'h0005, 16'h0003, 0, 4'b0000, hand(16'hFFFE, 1, 4'b0100, 4'b1111, "R4 subtract borrow"));
    drive(3, 16'h0003, 16'h0005, 0, 4'b0000, hand(16'h0001, 1, 4'b0001, 4'b1111, "R4 subtract with carry clear"));
    drive(4, 16'h1234, 16'h1234, 0, 4'b1000, hand(16'h0000, 0, 4'b0011, 4'b1111, "R4 compare equal"));
    drive(5, 16'h0001, 16'h9999, 0, 4'b1000, hand(16'h0000, 1, 4'b1011, 4'b0111, "R5 decimal word carry"));
    drive(5, 16'h0001, 16'h0099, 1, 4'b0000, hand(16'h0000, 1, 4'b0011, 4'b0111, "R5 decimal byte carry"));
    drive(5, 16'h5678, 16'h1234, 0, 4'b0001, hand(16'h6913, 1, 4'b0000, 4'b0111, "R5 decimal add with carry"));
    drive(7, 16'h00F0, 16'h000F, 0, 4'b1001, hand(16'h0000, 0, 4'b0010, 4'b1111, "R7 bit-test zero"));
    drive(6, 16'h8081, 16'hFF01, 0, 4'b1000, hand(16'h8001, 1, 4'b0101, 4'b1111, "R7 and nonzero"));
    drive(9, 16'h0F00, 16'h00F0, 0, 4'b1010, hand(16'h0FF0, 1, 4'b1010, 4'b0000, "R6 bit-set flags kept"));
    drive(8, 16'h00F0, 16'h00FF, 0, 4'b0101, hand(16'h000F, 1, 4'b0101, 4'b0000, "R6 bit-clear flags kept"));
    drive(10, 16'h8000, 16'h8001, 0, 4'b0000, hand(16'h0001, 1, 4'b1001, 4'b1111, "R8 xor both negative"));
    drive(11, 16'h0000, 16'h0081, 1, 4'b0001, hand(16'h00C0, 1, 4'b0101, 4'b1111, "R9 rotate byte carry in"));
    drive(12, 16'h0000, 16'h8002, 0, 4'b0001, hand(16'hC001, 1, 4'b0100, 4'b1111, "R9 arithmetic shift"));
    drive(13, 16'h0000, 16'h12AB, 1, 4'b0110, hand(16'hAB12, 1, 4'b0110, 4'b0000, "R12 swap ignores size"));
    drive(14, 16'h0000, 16'h3380, 1, 4'b1000, hand(16'hFF80, 1, 4'b0101, 4'b1111, "R12 sign-extend"));
    drive(15, 16'hFFFF, 16'hFFFF, 0, 4'b1111, hand(16'h0000, 0, 4'b1111, 4'b0000, "R1 unassigned code"));
    drive(1, 16'h00FF, 16'hFF00, 0, 4'b0001, hand(16'h0000, 1, 4'b0011, 4'b1111, "R2 add with carry wrap"));

    for (int i = 0; i < 400; i++) begin
      int o, s, d;
      bit b;
      logic [3:0] f;
      o = $urandom_range(0, 15);
      s = $urandom_range(0, 65535);
      d = $urandom_range(0, 65535);
      b = $urandom_range(0, 1);
      f = 4'($urandom_range(0, 15));
      if (o == 5) begin
        s = 0; d = 0;
        for (int k = 0; k < 4; k++) begin
          s = s | ($urandom_range(0, 9) << (4 * k));
          d = d | ($urandom_range(0, 9) << (4 * k));
        end
      end
      drive(o, s, d, b, f, model(o, s, d, b, f, $sformatf("R11 random op %0d (R2 R4 R10)", o)));
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule